// File: doc/BRIEF.md
# Edge-Triggered Input Capture and Count-Source Unit

This block is the input-capture part of a general-purpose timer. It watches a small set of external input pins, passes each through a two-stage synchroniser, and finds rising and falling transitions. On a transition that software has enabled for that pin, the block stores the timer's present count value in that pin's capture register. It also sets that pin's capture flag and, if the pin's interrupt enable is set, raises an interrupt.

The same pins can drive the timer itself. A count-control register either passes the prescaler tick through as the count-enable pulse (timer mode) or replaces it with transitions on one chosen pin (counter mode, on rising, falling or both transitions). The counter lives outside the block. The block takes the counter's value as an input and returns a one-cycle count-enable pulse.

Software reaches the block through a plain synchronous register port with write strobe, word address and registered read data.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, all capture values, capture flags, the interrupt output, the count-enable output and both control registers are zero.
- R2: A level change on a capture pin that is first sampled at clock edge k takes effect on the capture register, the flag and the count-enable pulse at edge k+2, and not before.
- R3: The capture-control register (address 0) holds three bits per channel starting at bit 3*ch: bit 3*ch enables capture on a rising transition, bit 3*ch+1 enables capture on a falling transition, and bit 3*ch+2 is the interrupt enable. An enabled transition loads `count_in` into the channel's capture register and sets its flag. A transition that is not enabled changes neither.
- R4: With both edge bits of a channel set, both transitions capture.
- R5: The flag register is at address 2. The capture flag of channel ch sits at bit 4+ch, and bits 3:0 read as zero. Writing 1 to a flag bit clears that flag, and writing 0 leaves it unchanged.
- R6: If a capture and a write-1 clear of the same flag fall in the same cycle, the flag ends up set and the capture value is updated.
- R7: `cap_irq` is high exactly when at least one channel has both its flag and its interrupt enable set.
- R8: The count-control register (address 1) has the mode in bits 1:0 and the input select in bits 3:2. In mode 00 (timer), `cnt_en` repeats `presc_tick` one cycle later, and the capture pins and the input select have no effect on it.
- R9: In modes 01, 10 and 11, `cnt_en` gives one one-cycle pulse for each rising, falling, or either transition respectively on the selected pin, and stays low otherwise. `presc_tick` and the pins that are not selected are ignored.
- R10: Read data is registered and shows, one cycle after the address is presented: capture control at 0, count control at 1, flags at 2, the capture value of channel ch at 3+ch, and zero at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| cap_pin | input | NCH | Asynchronous capture inputs |
| count_in | input | CW | Current timer counter value |
| presc_tick | input | 1 | Prescaler tick used in timer mode |
| cap_val | output | NCH*CW | Capture registers, channel ch at bits ch*CW upward |
| cap_flag | output | NCH | Per-channel capture flags |
| cap_irq | output | 1 | Capture interrupt request |
| cnt_en | output | 1 | One-cycle count-enable pulse for the counter |

## Verification
On every cycle, the assertions check the following:
- each detected transition matches the pin level two samples earlier;
- an enabled transition loads the counter value and sets the flag, even against a simultaneous clear;
- a capture register stays stable when there is no hit;
- the interrupt output agrees with the flags and enables;
- in timer mode the count-enable follows the tick, and in counter mode it stays low when no transition occurs.

Only the bench's scenarios can show the following:
- the exact bit layout of the control and flag registers;
- the full edge-selection sweep over every channel, with its absence of cross-talk;
- the pin-select decoding;
- the readback map.

// File: rtl/ecap_pkg.sv
package ecap_pkg;
  localparam int MAX_CH    = 4;
  localparam int SEL_W     = $clog2(MAX_CH);
  localparam int FLAG_BASE = 4;
  localparam int ADDR_CAPCTL = 0;
  localparam int ADDR_CNTCTL = 1;
  localparam int ADDR_FLAGS  = 2;
  localparam int ADDR_CAP0   = 3;

  typedef enum logic [1:0] {
    CNT_TIMER = 2'b00,
    CNT_RISE  = 2'b01,
    CNT_FALL  = 2'b10,
    CNT_BOTH  = 2'b11
  } cnt_mode_e;

  // Per-channel capture configuration: bit0 rise, bit1 fall, bit2 irq.
  typedef struct packed {
    logic irq_en;
    logic fall_en;
    logic rise_en;
  } cap_cfg_t;
endpackage

// File: rtl/ecap_sync_edge.sv
module ecap_sync_edge #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] pin,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall
);
  logic [NCH-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= pin;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_edge
      assign rise[g] = s2_q[g] & ~s3_q[g];
      assign fall[g] = ~s2_q[g] & s3_q[g];

      // R2: a detected rise reflects a high pin two samples earlier
      assert_rise_lat_R2: assert property (@(posedge clk) disable iff (rst)
        rise[g] |-> $past(pin[g], 2));
      assert_fall_lat_R2: assert property (@(posedge clk) disable iff (rst)
        fall[g] |-> !$past(pin[g], 2));
    end
  endgenerate
endmodule

// File: rtl/ecap_channel.sv
module ecap_channel
  import ecap_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          fall,
  input  cap_cfg_t      cfg,
  input  logic [CW-1:0] count_in,
  input  logic          clr,
  output logic [CW-1:0] cap_val,
  output logic          flag,
  output logic          flag_nxt
);
  logic hit;

  assign hit      = (rise & cfg.rise_en) | (fall & cfg.fall_en);
  assign flag_nxt = hit ? 1'b1 : (clr ? 1'b0 : flag);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_val <= '0;
      flag    <= 1'b0;
    end else begin
      if (hit) cap_val <= count_in;
      flag <= flag_nxt;
    end
  end

  assert_cap_load_R3: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cap_val == $past(count_in)));
  assert_cap_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !hit |=> $stable(cap_val));
  assert_flag_win_R6: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  assert_flag_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (clr && !hit) |=> !flag);
endmodule

// File: rtl/ecap_count_src.sv
module ecap_count_src
  import ecap_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_mode_e        mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             tick,
  input  logic [NCH-1:0]   rise,
  input  logic [NCH-1:0]   fall,
  output logic             cnt_en
);
  logic [MAX_CH-1:0] rise_x, fall_x;
  logic              sel_ok;
  logic              ev;

  assign rise_x = MAX_CH'(rise);
  assign fall_x = MAX_CH'(fall);
  assign sel_ok = (int'(sel) < NCH);

  always_comb begin
    ev = 1'b0;
    unique case (mode)
      CNT_TIMER: ev = tick;
      CNT_RISE:  ev = sel_ok & rise_x[sel];
      CNT_FALL:  ev = sel_ok & fall_x[sel];
      CNT_BOTH:  ev = sel_ok & (rise_x[sel] | fall_x[sel]);
      default:   ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_en <= 1'b0;
    else     cnt_en <= ev;
  end

  assert_timer_follow_R8: assert property (@(posedge clk) disable iff (rst)
    (mode == CNT_TIMER) |=> (cnt_en == $past(tick)));
  assert_ctr_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    ((mode != CNT_TIMER) && !(|rise) && !(|fall)) |=> !cnt_en);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecap_pkg::*;
#(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 3,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [NCH-1:0]    cap_pin,
  input  logic [CW-1:0]     count_in,
  input  logic              presc_tick,
  output logic [NCH*CW-1:0] cap_val,
  output logic [NCH-1:0]    cap_flag,
  output logic              cap_irq,
  output logic              cnt_en
);
  localparam int CFG_W = 3 * NCH;
  localparam int RW    = (CW < DW) ? CW : DW;

  cap_cfg_t [NCH-1:0] capcfg_q, capcfg_nxt;
  cnt_mode_e          mode_q;
  logic [SEL_W-1:0]   sel_q;
  logic [NCH-1:0]     rise, fall, clr, flag_nxt, ie_nxt, ie_q;
  logic [CW-1:0]      cap_arr [NCH];
  logic [DW-1:0]      rdata_d;
  logic               wr_cap, wr_cnt, wr_flg;

  assign wr_cap = bus_wr && (bus_addr == AW'(ADDR_CAPCTL));
  assign wr_cnt = bus_wr && (bus_addr == AW'(ADDR_CNTCTL));
  assign wr_flg = bus_wr && (bus_addr == AW'(ADDR_FLAGS));
  assign clr    = wr_flg ? bus_wdata[FLAG_BASE +: NCH] : '0;

  assign capcfg_nxt = wr_cap ? bus_wdata[CFG_W-1:0] : capcfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      capcfg_q <= '0;
      mode_q   <= CNT_TIMER;
      sel_q    <= '0;
    end else begin
      capcfg_q <= capcfg_nxt;
      if (wr_cnt) begin
        mode_q <= cnt_mode_e'(bus_wdata[1:0]);
        sel_q  <= bus_wdata[2 +: SEL_W];
      end
    end
  end

  ecap_sync_edge #(.NCH(NCH)) u_sync (
    .clk (clk),
    .rst (rst),
    .pin (cap_pin),
    .rise(rise),
    .fall(fall)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      ecap_channel #(.CW(CW)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise[g]),
        .fall    (fall[g]),
        .cfg     (capcfg_q[g]),
        .count_in(count_in),
        .clr     (clr[g]),
        .cap_val (cap_arr[g]),
        .flag    (cap_flag[g]),
        .flag_nxt(flag_nxt[g])
      );
      assign cap_val[g*CW +: CW] = cap_arr[g];
      assign ie_nxt[g] = capcfg_nxt[g].irq_en;
      assign ie_q[g]   = capcfg_q[g].irq_en;
    end
  endgenerate

  ecap_count_src #(.NCH(NCH)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .mode  (mode_q),
    .sel   (sel_q),
    .tick  (presc_tick),
    .rise  (rise),
    .fall  (fall),
    .cnt_en(cnt_en)
  );

  always_comb begin
    rdata_d = '0;
    if (bus_addr == AW'(ADDR_CAPCTL)) rdata_d[CFG_W-1:0] = capcfg_q;
    if (bus_addr == AW'(ADDR_CNTCTL)) rdata_d[2+SEL_W-1:0] = {sel_q, mode_q};
    if (bus_addr == AW'(ADDR_FLAGS))  rdata_d[FLAG_BASE +: NCH] = cap_flag;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(ADDR_CAP0 + i)) rdata_d[RW-1:0] = cap_arr[i][RW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      cap_irq   <= 1'b0;
    end else begin
      bus_rdata <= rdata_d;
      cap_irq   <= |(flag_nxt & ie_nxt);
    end
  end

  assert_irq_src_R7: assert property (@(posedge clk) disable iff (rst)
    cap_irq |-> (|(cap_flag & ie_q)));
  assert_irq_need_R7: assert property (@(posedge clk) disable iff (rst)
    (|(cap_flag & ie_q)) |-> cap_irq);
endmodule

// File: tb/edge_capture_unit_tb.sv
module edge_capture_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 3;
  localparam int DW  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic [NCH-1:0]    cap_pin = '0;
  logic [CW-1:0]     count_in = '0;
  logic              presc_tick = 1'b0;
  logic [NCH*CW-1:0] cap_val;
  logic [NCH-1:0]    cap_flag;
  logic              cap_irq;
  logic              cnt_en;

  int checks = 0;
  int fails  = 0;
  logic [CW-1:0] exp_cap [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  edge_capture_unit #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_pin(cap_pin),
    .count_in(count_in), .presc_tick(presc_tick), .cap_val(cap_val),
    .cap_flag(cap_flag), .cap_irq(cap_irq), .cnt_en(cnt_en)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input int a, input logic [DW-1:0] exp);
    bus_addr = AW'(a);
    @(negedge clk);
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NCH; i++) exp_cap[i] = '0;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 cap_val", 64'(cap_val[CW-1:0]) | 64'(cap_val[NCH*CW-1 -: CW]), 64'd0);
    check("R1 cap_flag", 64'(cap_flag), 64'd0);
    check("R1 cap_irq", 64'(cap_irq), 64'd0);
    check("R1 cnt_en", 64'(cnt_en), 64'd0);
    rd_check("R1 capctl", 0, '0);
    rd_check("R1 cntctl", 1, '0);

    // R3 R4 R7 sweep over channel and edge selection
    for (int ch = 0; ch < NCH; ch++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        logic ie;
        logic [DW-1:0] ctl;
        ie  = ch[0];
        ctl = (DW'({ie, cfg[1:0]})) << (3 * ch);
        wr(0, ctl);
        wr(2, 32'hF0);
        count_in = 32'h1000 + CW'(ch * 16 + cfg * 2);
        cap_pin[ch] = 1'b1;
        idle(3);
        if (cfg[0]) exp_cap[ch] = count_in;
        check("R3 rise value", 64'(cap_val[ch*CW +: CW]), 64'(exp_cap[ch]));
        check("R3 rise flag", 64'(cap_flag), 64'(cfg[0]) << ch);
        check("R7 rise irq", 64'(cap_irq), 64'(cfg[0] & ie));
        wr(2, 32'hF0);
        count_in = count_in + 1;
        cap_pin[ch] = 1'b0;
        idle(3);
        if (cfg[1]) exp_cap[ch] = count_in;
        check("R4 fall value", 64'(cap_val[ch*CW +: CW]), 64'(exp_cap[ch]));
        check("R4 fall flag", 64'(cap_flag), 64'(cfg[1]) << ch);
        check("R7 fall irq", 64'(cap_irq), 64'(cfg[1] & ie));
      end
    end

    // R2 latency
    wr(0, 32'h1);
    wr(2, 32'hF0);
    count_in = 32'h2222;
    cap_pin[0] = 1'b1;
    idle(2);
    check("R2 early flag", 64'(cap_flag[0]), 64'd0);
    idle(1);
    check("R2 on-time flag", 64'(cap_flag[0]), 64'd1);
    exp_cap[0] = 32'h2222;

    // R5 flag register layout and write-1-clear
    rd_check("R5 flag layout", 2, 32'h10);
    wr(2, 32'h0F);
    rd_check("R5 write zero no effect", 2, 32'h10);

    // R6 simultaneous capture and clear
    wr(0, 32'h3);
    count_in = 32'h3333;
    cap_pin[0] = 1'b0;
    idle(2);
    wr(2, 32'h10);
    check("R6 flag wins", 64'(cap_flag[0]), 64'd1);
    check("R6 value", 64'(cap_val[CW-1:0]), 64'h3333);
    exp_cap[0] = 32'h3333;
    wr(2, 32'h10);
    check("R5 cleared", 64'(cap_flag[0]), 64'd0);

    // R10 readback map
    wr(0, 32'hFABC);
    rd_check("R10 capctl", 0, 32'hABC);
    wr(1, 32'hE);
    rd_check("R10 cntctl", 1, 32'hE);
    for (int ch = 0; ch < NCH; ch++) rd_check("R10 capture value", 3 + ch, exp_cap[ch]);
    rd_check("R10 unused", 7, '0);
    wr(0, 32'h0);

    // R8 timer mode, select field ignored
    wr(1, 32'h8);
    for (int k = 0; k < 9; k++) begin
      logic t;
      t = (k % 3 == 0);
      presc_tick = t;
      @(negedge clk);
      check("R8 tick follow", 64'(cnt_en), 64'(t));
    end
    presc_tick = 1'b0;
    cap_pin[2] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R8 pin ignored", 64'(cnt_en), 64'd0);
    end
    cap_pin[2] = 1'b0;
    idle(4);

    // R9 counter modes on pin 1
    for (int m = 1; m < 4; m++) begin
      wr(1, DW'((1 << 2) | m));
      presc_tick = 1'b1;
      for (int lvl = 1; lvl >= 0; lvl--) begin
        logic expct;
        expct = (lvl == 1) ? m[0] : m[1];
        cap_pin[1] = lvl[0];
        for (int s = 1; s <= 5; s++) begin
          @(negedge clk);
          check("R9 edge pulse", 64'(cnt_en), 64'((s == 3) && expct));
        end
      end
      cap_pin[3] = ~cap_pin[3];
      for (int s = 1; s <= 5; s++) begin
        @(negedge clk);
        check("R9 other pin ignored", 64'(cnt_en), 64'd0);
      end
      presc_tick = 1'b0;
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule